// File: doc/BRIEF.md
# Multiplexed host bus to Wishbone bridge

This block is a synchronous slave for a processor's 16-bit external bus in which a single set of shared lines carries first the address and then the data of each access. Chip select (active low) frames the access, a one-clock low pulse on the address-valid strobe marks the address phase, and a read/write line gives the direction once the data window opens. Everything runs on the host bus clock, nominally 99 MHz. The host grants a fixed window of wait-state clocks after the address phase (four by default) and takes no ready signal. The bridge has to finish its work inside that window.

For each access the bridge latches the address and decides the direction in the first wait clock. It then launches exactly one 16-bit Wishbone master cycle with all byte selects set and holds it until acknowledge. On reads, the returned word is driven back onto the shared lines before the window closes. If acknowledge is too late, the bridge abandons the cycle. It then returns the last read word it held and pulses a timeout flag. One reserved address (all ones) is not forwarded to Wishbone. It reaches a local interrupt-enable bit, and that bit qualifies an interrupt source level onto the interrupt output to the host.

The controller has four states:
- ST_IDLE waits for an address phase.
- ST_DECODE is the first wait clock. It fixes the direction and either launches the Wishbone cycle or serves the reserved address locally.
- ST_WB_RUN holds the Wishbone cycle.
- ST_HOLD keeps the result until chip select rises.

The transitions are:
- ST_IDLE goes to ST_DECODE on an address phase.
- ST_DECODE goes to ST_WB_RUN for a forwarded address, or to ST_HOLD for the reserved address.
- ST_WB_RUN goes to ST_HOLD on acknowledge or on budget expiry.
- Any state except ST_IDLE goes back to ST_IDLE when chip select is sampled high.

Top module: `hbus_wb_bridge`

## Requirements
- R1: The address on the shared lines is captured in the clock where chip select and address-valid are both sampled low, and it appears on `wb_adr_o` for the whole Wishbone cycle.
- R2: For a forwarded address, `wb_cyc_o` and `wb_stb_o` rise in the second wait clock. `wb_sel_o` is all ones. `wb_we_o` is high when `hb_rw` equals the parameter `RW_WR_LVL` (default 1, so 1 means write), sampled in the first wait clock. `wb_dat_o` carries the word on the shared lines in the first wait clock.
- R3: The Wishbone cycle stays asserted until acknowledge and is low in the clock after acknowledge is sampled.
- R4: For a read acknowledged within the first `WAIT_CYCLES-2` clocks of the cycle, the acknowledged word is on `hb_ad_o` in the last wait clock.
- R5: If no acknowledge arrives within `WAIT_CYCLES-2` clocks, the cycle is dropped. `timeout_o` is high for exactly one clock, the last wait clock, and `hb_ad_o` keeps the last read word the bridge returned.
- R6: `hb_ad_oe` is high only while chip select is low during a read, from the second wait clock onward. It is low during writes, in the first wait clock, and as soon as chip select is high.
- R7: Chip select sampled high in any non-idle state ends the Wishbone cycle at that edge and returns the bridge to idle.
- R8: Address 16'hFFFF starts no Wishbone cycle. A write there loads data bit 0 into the interrupt enable. A read there returns {15'b0, enable} on `hb_ad_o`.
- R9: `irq_o` equals `irq_src_i` AND the interrupt enable.
- R10: After reset there is no Wishbone cycle, no bus drive, no timeout, and the interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_cs_n | input | 1 | Chip select, active low |
| hb_adv_n | input | 1 | Address-valid strobe, active low |
| hb_rw | input | 1 | Read/write line, write level set by RW_WR_LVL |
| hb_ad_i | input | 16 | Shared address/data lines, input side |
| hb_ad_o | output | 16 | Shared lines, output side (read data) |
| hb_ad_oe | output | 1 | Pad drive enable for hb_ad_o |
| wb_adr_o | output | 16 | Wishbone address |
| wb_dat_o | output | 16 | Wishbone write data |
| wb_dat_i | input | 16 | Wishbone read data |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_sel_o | output | 2 | Wishbone byte selects |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| timeout_o | output | 1 | One-clock pulse when acknowledge misses the window |
| irq_src_i | input | 1 | Interrupt source level |
| irq_o | output | 1 | Interrupt to host |

## Verification
A controller stuck outside ST_IDLE shows at the ports in the very next access. Either no Wishbone cycle appears in the second wait clock, or `wb_cyc_o` stays high after chip select rises. A wrong direction or a misrouted decode shows as a wrong `wb_we_o`, as the bus driven during a write, or as a stray cycle for the reserved address, all within two clocks of the address phase. A bad budget count shows in the last wait clock, either as a missing or extra `timeout_o` pulse or as stale rather than fresh data on `hb_ad_o`.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_WB_RUN = 2'd2,
        ST_HOLD   = 2'd3
    } hbb_state_e;

endpackage

// File: rtl/hbb_seq.sv
module hbb_seq
    import hbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       adv_n,
    input  logic       wr_req,
    input  logic       ctrl_hit,
    input  logic       ack_taken,
    input  logic       expired,
    output hbb_state_e state_o,
    output logic       addr_load,
    output logic       launch,
    output logic       wb_stop,
    output logic       ctrl_wr,
    output logic       ctrl_rd,
    output logic       rdata_take,
    output logic       read_active,
    output logic       timeout_o
);

    hbb_state_e state_q, state_d;
    logic       dir_wr_q;
    logic       to_set;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n && !adv_n) state_d = ST_DECODE;
            end
            ST_DECODE: begin
                if (cs_n)          state_d = ST_IDLE;
                else if (ctrl_hit) state_d = ST_HOLD;
                else               state_d = ST_WB_RUN;
            end
            ST_WB_RUN: begin
                if (cs_n)                      state_d = ST_IDLE;
                else if (ack_taken || expired) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cs_n) state_d = ST_IDLE;
            end
        endcase
    end

    // control outputs
    always_comb begin
        addr_load  = 1'b0;
        launch     = 1'b0;
        wb_stop    = 1'b0;
        ctrl_wr    = 1'b0;
        ctrl_rd    = 1'b0;
        rdata_take = 1'b0;
        to_set     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                addr_load = !cs_n && !adv_n;
            end
            ST_DECODE: begin
                if (!cs_n) begin
                    if (ctrl_hit) begin
                        ctrl_wr = wr_req;
                        ctrl_rd = !wr_req;
                    end else begin
                        launch = 1'b1;
                    end
                end
            end
            ST_WB_RUN: begin
                if (cs_n) begin
                    wb_stop = 1'b1;
                end else if (ack_taken) begin
                    wb_stop    = 1'b1;
                    rdata_take = !dir_wr_q;
                end else if (expired) begin
                    wb_stop = 1'b1;
                    to_set  = 1'b1;
                end
            end
            ST_HOLD: begin
            end
        endcase
    end

    // direction, drive flag and timeout pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_wr_q    <= 1'b0;
            read_active <= 1'b0;
            timeout_o   <= 1'b0;
        end else begin
            timeout_o <= to_set;
            if (state_q == ST_DECODE && !cs_n) begin
                dir_wr_q    <= wr_req;
                read_active <= !wr_req;
            end else if (state_d == ST_IDLE) begin
                read_active <= 1'b0;
            end
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/hbb_wb_port.sv
module hbb_wb_port #(
    parameter int AD_W   = 16,
    parameter int BUDGET = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic            stop,
    input  logic            we_in,
    input  logic [AD_W-1:0] adr_in,
    input  logic [AD_W-1:0] dat_in,
    input  logic            wb_ack_i,
    output logic [AD_W-1:0] wb_adr_o,
    output logic [AD_W-1:0] wb_dat_o,
    output logic            wb_we_o,
    output logic [AD_W/8-1:0] wb_sel_o,
    output logic            wb_stb_o,
    output logic            wb_cyc_o,
    output logic            ack_taken,
    output logic            expired
);

    localparam int SEL_W = AD_W / 8;
    localparam int CNT_W = (BUDGET > 1) ? $clog2(BUDGET) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUDGET - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q    <= 1'b0;
            cnt_q    <= '0;
            wb_adr_o <= '0;
            wb_dat_o <= '0;
            wb_we_o  <= 1'b0;
        end else if (launch) begin
            cyc_q    <= 1'b1;
            cnt_q    <= '0;
            wb_adr_o <= adr_in;
            wb_dat_o <= dat_in;
            wb_we_o  <= we_in;
        end else if (stop) begin
            cyc_q <= 1'b0;
        end else if (cyc_q && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wb_sel_o  = {SEL_W{1'b1}};
    assign wb_cyc_o  = cyc_q;
    assign wb_stb_o  = cyc_q;
    assign ack_taken = cyc_q && wb_ack_i;
    assign expired   = cyc_q && (cnt_q == LAST);

endmodule

// File: rtl/hbb_irq_gate.sv
module hbb_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic irq_src_i,
    output logic en_q,
    output logic irq_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (wr_en) begin
            en_q <= wr_bit;
        end
    end

    assign irq_o = irq_src_i && en_q;

endmodule

// File: rtl/hbus_wb_bridge.sv
module hbus_wb_bridge
    import hbb_pkg::*;
#(
    parameter int          AD_W        = 16,
    parameter int          WAIT_CYCLES = 4,
    parameter logic        RW_WR_LVL   = 1'b1,
    parameter logic [15:0] CTRL_ADDR   = 16'hFFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hb_cs_n,
    input  logic            hb_adv_n,
    input  logic            hb_rw,
    input  logic [AD_W-1:0] hb_ad_i,
    output logic [AD_W-1:0] hb_ad_o,
    output logic            hb_ad_oe,
    output logic [AD_W-1:0] wb_adr_o,
    output logic [AD_W-1:0] wb_dat_o,
    input  logic [AD_W-1:0] wb_dat_i,
    output logic            wb_we_o,
    output logic [AD_W/8-1:0] wb_sel_o,
    output logic            wb_stb_o,
    output logic            wb_cyc_o,
    input  logic            wb_ack_i,
    output logic            timeout_o,
    input  logic            irq_src_i,
    output logic            irq_o
);

    localparam int BUDGET = WAIT_CYCLES - 2;

    hbb_state_e      state;
    logic [AD_W-1:0] addr_q;
    logic [AD_W-1:0] rdata_q;
    logic            wr_req, ctrl_hit;
    logic            addr_load, launch, wb_stop;
    logic            ctrl_wr, ctrl_rd, rdata_take, read_active;
    logic            ack_taken, expired, irq_en;

    assign wr_req   = (hb_rw == RW_WR_LVL);
    assign ctrl_hit = (addr_q == AD_W'(CTRL_ADDR));

    hbb_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (hb_cs_n),
        .adv_n      (hb_adv_n),
        .wr_req     (wr_req),
        .ctrl_hit   (ctrl_hit),
        .ack_taken  (ack_taken),
        .expired    (expired),
        .state_o    (state),
        .addr_load  (addr_load),
        .launch     (launch),
        .wb_stop    (wb_stop),
        .ctrl_wr    (ctrl_wr),
        .ctrl_rd    (ctrl_rd),
        .rdata_take (rdata_take),
        .read_active(read_active),
        .timeout_o  (timeout_o)
    );

    hbb_wb_port #(
        .AD_W  (AD_W),
        .BUDGET(BUDGET)
    ) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .stop     (wb_stop),
        .we_in    (wr_req),
        .adr_in   (addr_q),
        .dat_in   (hb_ad_i),
        .wb_ack_i (wb_ack_i),
        .wb_adr_o (wb_adr_o),
        .wb_dat_o (wb_dat_o),
        .wb_we_o  (wb_we_o),
        .wb_sel_o (wb_sel_o),
        .wb_stb_o (wb_stb_o),
        .wb_cyc_o (wb_cyc_o),
        .ack_taken(ack_taken),
        .expired  (expired)
    );

    hbb_irq_gate u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .wr_bit   (hb_ad_i[0]),
        .irq_src_i(irq_src_i),
        .en_q     (irq_en),
        .irq_o    (irq_o)
    );

    // address latch and read-return register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (addr_load) addr_q <= hb_ad_i;
            if (rdata_take)   rdata_q <= wb_dat_i;
            else if (ctrl_rd) rdata_q <= {{(AD_W-1){1'b0}}, irq_en};
        end
    end

    assign hb_ad_o  = rdata_q;
    assign hb_ad_oe = !hb_cs_n && read_active && (state != ST_IDLE);

endmodule

// File: rtl/hbb_checker.sv
module hbb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        hb_cs_n,
    input logic        hb_ad_oe,
    input logic [15:0] wb_adr_o,
    input logic        wb_cyc_o,
    input logic        wb_ack_i,
    input logic        timeout_o,
    input logic        irq_src_i,
    input logic        irq_o
);

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i && !hb_cs_n) |=> (wb_cyc_o || timeout_o)); // R3
    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o); // R3
    AST_ADR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i && !hb_cs_n) |=> (!wb_cyc_o || $stable(wb_adr_o))); // R1
    AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o); // R5
    AST_TIMEOUT_NO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !wb_cyc_o); // R5
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        hb_ad_oe |-> !hb_cs_n); // R6
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        hb_cs_n |=> !wb_cyc_o); // R7
    AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_src_i); // R9

endmodule

bind hbus_wb_bridge hbb_checker i_chk (.*);

// File: tb/test_hbus_wb_bridge.sv
module test_hbus_wb_bridge;

    localparam logic WR = 1'b1;
    localparam logic RD = 1'b0;
    localparam logic [15:0] CTRL = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_cs_n = 1'b1, hb_adv_n = 1'b1, hb_rw = 1'b0;
    logic [15:0] hb_ad_i = '0, hb_ad_o;
    logic        hb_ad_oe;
    logic [15:0] wb_adr_o, wb_dat_o, wb_dat_i = '0;
    logic        wb_we_o, wb_stb_o, wb_cyc_o, wb_ack_i = 1'b0;
    logic [1:0]  wb_sel_o;
    logic        timeout_o, irq_src_i = 1'b0, irq_o;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] mem [16];
    logic [15:0] last_rd = '0;
    logic        en_model = 1'b0;

    always #10 clk = ~clk;

    hbus_wb_bridge i_hbus_wb_bridge (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_expect(bit ctrl, bit took, logic [15:0] ackd);
        if (ctrl) return {15'b0, en_model};
        if (took) return ackd;
        return last_rd;
    endfunction

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input int lat);
        bit ctrl = (a == CTRL);
        bit took = 0;
        logic [15:0] ackd = '0;
        logic [15:0] exp;
        @(negedge clk);
        hb_cs_n = 0; hb_adv_n = 0; hb_rw = RD; hb_ad_i = a; wb_ack_i = 0;
        @(negedge clk);
        hb_adv_n = 1; hb_rw = wr ? WR : RD; hb_ad_i = wr ? d : 16'h5A5A;
        #1 chk("R6 no drive in first wait clock", hb_ad_oe, 0);
        for (int w = 2; w <= 4; w++) begin
            @(negedge clk);
            wb_ack_i = 0;
            if (w == 2) begin
                chk(ctrl ? "R8 no cycle for reserved address" : "R2 cycle launched", wb_cyc_o, !ctrl);
                chk("R2 strobe", wb_stb_o, !ctrl);
                if (!ctrl) begin
                    chk("R1 address", wb_adr_o, a);
                    chk("R2 write enable", wb_we_o, wr);
                    chk("R2 select", wb_sel_o, 2'b11);
                    if (wr) chk("R2 write data", wb_dat_o, d);
                end
            end
            if (w == 3 && !ctrl) chk("R3 cycle held until ack", wb_cyc_o, lat >= 1);
            if (!ctrl && wb_cyc_o && (w - 2) == lat) begin
                wb_ack_i = 1;
                ackd = mem[a[3:0]];
                wb_dat_i = ackd;
                if (wr) mem[a[3:0]] = d;
                took = 1;
            end
            if (w == 4) begin
                chk("R5 timeout pulse", timeout_o, !ctrl && !took);
                chk("R3 cycle ended", wb_cyc_o, 0);
                chk("R6 drive during read", hb_ad_oe, !wr);
                if (!wr) begin
                    exp = rd_expect(ctrl, took, ackd);
                    chk(ctrl ? "R8 reserved read" : (took ? "R4 read data" : "R5 stale data"), hb_ad_o, exp);
                    last_rd = exp;
                end else if (ctrl) begin
                    en_model = d[0];
                end
            end
        end
        @(negedge clk);
        hb_cs_n = 1; wb_ack_i = 0; hb_ad_i = 16'($urandom);
        #1 chk("R6 released with chip select", hb_ad_oe, 0);
        @(negedge clk);
        chk("R5 timeout gone", timeout_o, 0);
        chk("R9 irq level", irq_o, irq_src_i & en_model);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20211));
        for (int i = 0; i < 16; i++) mem[i] = 16'($urandom);
        irq_src_i = 1;
        repeat (3) @(negedge clk);
        chk("R10 no cycle in reset", wb_cyc_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R10 no cycle", wb_cyc_o, 0);
        chk("R10 no drive", hb_ad_oe, 0);
        chk("R10 no timeout", timeout_o, 0);
        chk("R10 irq disabled", irq_o, 0);

        // directed
        access(RD, CTRL, 0, 0);                 // R8 read enable = 0
        access(WR, CTRL, 16'h0001, 0);          // R8 write enable
        chk("R9 irq with enable", irq_o, 1);
        access(RD, CTRL, 0, 0);                 // R8 read back 1
        access(WR, 16'h0012, 16'hBEEF, 0);      // R2 write, fast ack
        access(RD, 16'h0012, 0, 1);             // R4 read, slow ack
        access(RD, 16'h0033, 0, 3);             // R5 timeout keeps old word
        access(WR, 16'h0044, 16'h1234, 2);      // R5 write timeout
        irq_src_i = 0;
        access(WR, CTRL, 16'h0000, 0);          // R9 disable

        // R7 abort in the middle of a cycle
        @(negedge clk);
        hb_cs_n = 0; hb_adv_n = 0; hb_rw = RD; hb_ad_i = 16'h0101;
        @(negedge clk);
        hb_adv_n = 1;
        @(negedge clk);
        chk("R7 cycle running before abort", wb_cyc_o, 1);
        hb_cs_n = 1;
        #1 chk("R7 drive released", hb_ad_oe, 0);
        @(negedge clk);
        chk("R7 cycle dropped on chip select", wb_cyc_o, 0);
        chk("R7 no timeout after abort", timeout_o, 0);
        @(negedge clk);

        // random mix
        for (int i = 0; i < 80; i++) begin
            logic [15:0] a = 16'($urandom);
            int r = int'($urandom % 8);
            if (r == 0) a = CTRL;
            else if (a == CTRL) a = 16'h0;
            irq_src_i = 1'($urandom);
            access(1'($urandom), a, 16'($urandom), int'($urandom % 4));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule